// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This unit sits between the execute stage of a core and a 64-bit data memory port. The execute stage hands it one memory operation at a time: an address, an access size (byte, halfword, word or doubleword), a store flag, an unsigned flag for loads and the store data. The unit turns that into a memory request on a doubleword-aligned address. The request carries byte enables for the addressed lanes and, for stores, the data moved into those lanes. For loads, it picks the addressed bytes out of the returned doubleword and widens them to 64 bits. The widening copies the sign bit, or fills with zeros when the unsigned flag is set.

The unit has no arithmetic path and never splits an access. An access whose address is not a multiple of its size never reaches memory. Instead the unit raises a one-cycle exception pulse that carries the faulting address and whether the access was a store. Only one operation is in flight at a time. The execute side sees a valid/ready handshake. The memory side sees a request valid/ready handshake and a read-data valid strobe.

Top module: `lsu_align`

## Requirements
- R1: After reset, req_ready is 1 and mem_valid, ld_valid and exc_valid are 0.
- R2: An aligned request accepted on a clock edge (req_valid and req_ready both 1) drives mem_valid to 1 after that edge. mem_addr is the request address with its low three bits cleared, and mem_we equals req_store. All mem_* request outputs hold steady until an edge where mem_ready is 1, and mem_valid is 0 after that edge.
- R3: mem_be has 2^size contiguous ones starting at bit addr[2:0], where req_size encodes 0=byte, 1=halfword, 2=word, 3=doubleword.
- R4: For a store, mem_wdata holds the low 2^size bytes of req_wdata shifted up by 8*addr[2:0] bits. Lanes that are not enabled are 0.
- R5: A byte, halfword or word load with req_unsigned=0 returns the addressed bytes of mem_rdata with their top bit copied into all upper bits of ld_data.
- R6: A byte, halfword or word load with req_unsigned=1 returns the addressed bytes with zeros in all upper bits of ld_data.
- R7: A doubleword load returns all 64 bits of mem_rdata unchanged, whatever req_unsigned is.
- R8: A request with addr not a multiple of 2^size produces no memory request. exc_valid is 1 for exactly one cycle after the accepting edge, with exc_addr equal to the full request address and exc_store equal to req_store.
- R9: req_ready is 0 from the accepting edge until the operation completes: store handshake, load data return, or the end of the exception pulse. Requests presented while req_ready is 0 are ignored and cause no later memory request.
- R10: ld_valid is 1 for exactly one cycle, after the edge at which mem_rvalid is sampled 1 while a load awaits its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Execute stage presents an operation |
| req_ready | output | 1 | Unit can accept an operation |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_unsigned | input | 1 | Zero-extend load result |
| req_addr | input | AW | Byte address |
| req_wdata | input | 64 | Store data, right-justified |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Doubleword-aligned address |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Lane-placed write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read doubleword |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended load result |
| exc_valid | output | 1 | Misaligned access pulse |
| exc_store | output | 1 | Faulting access was a store |
| exc_addr | output | AW | Faulting address |

## Verification
The memory request outputs are registered, and so is the exception pulse. Both therefore appear one cycle after the edge that accepts the operation. The load result appears one cycle after the edge that samples mem_rvalid. The bench drives inputs on falling edges and samples every output on the next falling edge, so each check lands half a cycle after the register that produces the value. The bench follows an operation through its handshake edges and checks req_ready at each step. This confirms the busy window and that later idle cycles carry no stray request or pulse.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned LSU_DW   = 64;
  localparam int unsigned LSU_LN   = LSU_DW / 8;
  localparam int unsigned LSU_OFFW = $clog2(LSU_LN);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  // data mask covering the low 2^size bytes
  function automatic logic [LSU_DW-1:0] size_mask(input acc_size_e sz);
    logic [LSU_DW-1:0] m;
    case (sz)
      SZ_BYTE: m = {{(LSU_DW-8){1'b0}}, 8'hFF};
      SZ_HALF: m = {{(LSU_DW-16){1'b0}}, 16'hFFFF};
      SZ_WORD: m = {{(LSU_DW-32){1'b0}}, 32'hFFFF_FFFF};
      default: m = '1;
    endcase
    return m;
  endfunction

  // unshifted byte-enable pattern for a size
  function automatic logic [LSU_LN-1:0] size_lanes(input acc_size_e sz);
    logic [LSU_LN-1:0] b;
    case (sz)
      SZ_BYTE: b = {{(LSU_LN-1){1'b0}}, 1'b1};
      SZ_HALF: b = {{(LSU_LN-2){1'b0}}, 2'b11};
      SZ_WORD: b = {{(LSU_LN-4){1'b0}}, 4'hF};
      default: b = '1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lsu_req_align.sv
module lsu_req_align
  import lsu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]     addr,
  input  acc_size_e         size,
  input  logic [LSU_DW-1:0] wdata,
  output logic              misaligned,
  output logic [AW-1:0]     line_addr,
  output logic [LSU_LN-1:0] lane_en,
  output logic [LSU_DW-1:0] lane_wdata
);
  logic [LSU_OFFW-1:0] off;
  logic [LSU_OFFW-1:0] low_mask;

  always_comb begin
    off = addr[LSU_OFFW-1:0];
    case (size)
      SZ_BYTE: low_mask = '0;
      SZ_HALF: low_mask = LSU_OFFW'(1);
      SZ_WORD: low_mask = LSU_OFFW'(3);
      default: low_mask = LSU_OFFW'(7);
    endcase
    misaligned = |(off & low_mask);
    line_addr  = {addr[AW-1:LSU_OFFW], {LSU_OFFW{1'b0}}};
    lane_en    = size_lanes(size) << off;
    lane_wdata = (wdata & size_mask(size)) << {off, 3'b000};
  end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
  import lsu_pkg::*;
(
  input  logic [LSU_DW-1:0]   rdata,
  input  logic [LSU_OFFW-1:0] off,
  input  acc_size_e           size,
  input  logic                zext,
  output logic [LSU_DW-1:0]   result
);
  logic [LSU_DW-1:0] shifted;
  logic [LSU_DW-1:0] keep;
  logic              top_bit;

  always_comb begin
    shifted = rdata >> {off, 3'b000};
    keep    = size_mask(size);
    case (size)
      SZ_BYTE: top_bit = shifted[7];
      SZ_HALF: top_bit = shifted[15];
      SZ_WORD: top_bit = shifted[31];
      default: top_bit = 1'b0;
    endcase
    result = (shifted & keep) | ((!zext && top_bit) ? ~keep : '0);
  end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_store,
  input  acc_size_e           req_size,
  input  logic                req_unsigned,
  input  logic [AW-1:0]       req_addr,
  input  logic                misaligned,
  input  logic [AW-1:0]       line_addr,
  input  logic [LSU_LN-1:0]   lane_en,
  input  logic [LSU_DW-1:0]   lane_wdata,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [LSU_LN-1:0]   mem_be,
  output logic [LSU_DW-1:0]   mem_wdata,
  input  logic                mem_rvalid,
  output logic [LSU_OFFW-1:0] ld_off,
  output acc_size_e           ld_size,
  output logic                ld_zext,
  input  logic [LSU_DW-1:0]   ext_data,
  output logic                ld_valid,
  output logic [LSU_DW-1:0]   ld_data,
  output logic                exc_valid,
  output logic                exc_store,
  output logic [AW-1:0]       exc_addr
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;

  state_e state_q, state_d;
  logic   accept, issue_en, exc_en, ret_en;

  assign req_ready = (state_q == ST_IDLE) && !exc_valid;
  assign accept    = req_valid && req_ready;
  assign issue_en  = accept && !misaligned;
  assign exc_en    = accept && misaligned;
  assign ret_en    = (state_q == ST_WAIT) && mem_rvalid;
  assign mem_valid = (state_q == ST_ISSUE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (issue_en) state_d = ST_ISSUE;
      ST_ISSUE: if (mem_ready) state_d = mem_we ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (mem_rvalid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      exc_valid <= 1'b0;
      ld_valid  <= 1'b0;
    end else begin
      state_q   <= state_d;
      exc_valid <= exc_en;
      ld_valid  <= ret_en;
    end
  end

  // request payload, captured only on an issued operation
  always_ff @(posedge clk) begin
    if (issue_en) begin
      mem_we    <= req_store;
      mem_addr  <= line_addr;
      mem_be    <= lane_en;
      mem_wdata <= req_store ? lane_wdata : '0;
      ld_off    <= req_addr[LSU_OFFW-1:0];
      ld_size   <= req_size;
      ld_zext   <= req_unsigned;
    end
  end

  always_ff @(posedge clk) begin
    if (exc_en) begin
      exc_addr  <= req_addr;
      exc_store <= req_store;
    end
  end

  always_ff @(posedge clk) begin
    if (ret_en) ld_data <= ext_data;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_we) && $stable(mem_wdata));
  p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !misaligned |=> mem_valid);
  p_be_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                   $countones(mem_be) == 4 || $countones(mem_be) == 8));
  p_exc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);
  p_exc_noissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !mem_valid);
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_ld_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_be,
  output logic [63:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata,
  output logic          ld_valid,
  output logic [63:0]   ld_data,
  output logic          exc_valid,
  output logic          exc_store,
  output logic [AW-1:0] exc_addr
);
  acc_size_e           size_in;
  logic                mis;
  logic [AW-1:0]       line_addr;
  logic [LSU_LN-1:0]   lane_en;
  logic [LSU_DW-1:0]   lane_wdata;
  logic [LSU_OFFW-1:0] ld_off;
  acc_size_e           ld_size;
  logic                ld_zext;
  logic [LSU_DW-1:0]   ext_data;

  assign size_in = acc_size_e'(req_size);

  lsu_req_align #(.AW(AW)) u_req (
    .addr(req_addr), .size(size_in), .wdata(req_wdata),
    .misaligned(mis), .line_addr(line_addr), .lane_en(lane_en),
    .lane_wdata(lane_wdata)
  );

  lsu_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(size_in), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .misaligned(mis), .line_addr(line_addr), .lane_en(lane_en),
    .lane_wdata(lane_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid),
    .ld_off(ld_off), .ld_size(ld_size), .ld_zext(ld_zext), .ext_data(ext_data),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .exc_valid(exc_valid), .exc_store(exc_store), .exc_addr(exc_addr)
  );

  lsu_load_extend u_ext (
    .rdata(mem_rdata), .off(ld_off), .size(ld_size), .zext(ld_zext),
    .result(ext_data)
  );
endmodule

// File: tb/lsu_align_tb.sv
`timescale 1ns/1ps
module lsu_align_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata;
  logic        ld_valid, exc_valid, exc_store;
  logic [63:0] ld_data;
  logic [31:0] exc_addr;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lsu_align u_dut (.*);

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        uns;
    logic [31:0] addr;
    logic [63:0] data;
    logic [7:0]  be;
    logic [63:0] expd;
    logic        mis;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h1003, 64'h1122334455667788, 8'h08, 64'h0000000088000000, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h1006, 64'h1122334455667788, 8'hC0, 64'h7788000000000000, 1'b0},
    '{1'b1, 2'd2, 1'b0, 32'h1004, 64'h1122334455667788, 8'hF0, 64'h5566778800000000, 1'b0},
    '{1'b1, 2'd3, 1'b0, 32'h1008, 64'h1122334455667788, 8'hFF, 64'h1122334455667788, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h1005, 64'h1122334455667788, 8'h00, 64'h0, 1'b1},
    '{1'b1, 2'd2, 1'b0, 32'h1002, 64'h1122334455667788, 8'h00, 64'h0, 1'b1},
    '{1'b0, 2'd0, 1'b0, 32'h1001, 64'hF0E1D2C3B4A59687, 8'h02, 64'hFFFFFFFFFFFFFF96, 1'b0},
    '{1'b0, 2'd0, 1'b1, 32'h1007, 64'hF0E1D2C3B4A59687, 8'h80, 64'h00000000000000F0, 1'b0},
    '{1'b0, 2'd1, 1'b0, 32'h1002, 64'hF0E1D2C3B4A59687, 8'h0C, 64'hFFFFFFFFFFFFB4A5, 1'b0},
    '{1'b0, 2'd1, 1'b1, 32'h1006, 64'hF0E1D2C3B4A59687, 8'hC0, 64'h000000000000F0E1, 1'b0},
    '{1'b0, 2'd2, 1'b0, 32'h1004, 64'hF0E1D2C3B4A59687, 8'hF0, 64'hFFFFFFFFF0E1D2C3, 1'b0},
    '{1'b0, 2'd2, 1'b1, 32'h1000, 64'hF0E1D2C3B4A59687, 8'h0F, 64'h00000000B4A59687, 1'b0},
    '{1'b0, 2'd3, 1'b1, 32'h1010, 64'hF0E1D2C3B4A59687, 8'hFF, 64'hF0E1D2C3B4A59687, 1'b0},
    '{1'b0, 2'd2, 1'b0, 32'h1000, 64'h0011223344556677, 8'h0F, 64'h0000000044556677, 1'b0},
    '{1'b0, 2'd0, 1'b0, 32'h1005, 64'h0011223344556677, 8'h20, 64'h0000000000000022, 1'b0},
    '{1'b0, 2'd3, 1'b0, 32'h100C, 64'h0, 8'h00, 64'h0, 1'b1},
    '{1'b0, 2'd1, 1'b0, 32'h1003, 64'h0, 8'h00, 64'h0, 1'b1}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive_req(input logic st, input logic [1:0] sz, input logic uns,
                           input logic [31:0] a, input logic [63:0] d);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    req_addr = a; req_wdata = d;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
    req_unsigned = 1'b0; req_addr = '0; req_wdata = '0;
    mem_ready = 1'b1; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 mem_valid", 64'(mem_valid), 64'd0);
    check("R1 ld_valid",  64'(ld_valid),  64'd0);
    check("R1 exc_valid", 64'(exc_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      check("R9 ready before request", 64'(req_ready), 64'd1);
      drive_req(v.st, v.sz, v.uns, v.addr, v.data);
      @(negedge clk);
      req_valid = 1'b0;
      if (v.mis) begin
        check("R8 exc_valid", 64'(exc_valid), 64'd1);
        check("R8 exc_addr",  64'(exc_addr),  64'(v.addr));
        check("R8 exc_store", 64'(exc_store), 64'(v.st));
        check("R8 no mem_valid", 64'(mem_valid), 64'd0);
        check("R9 ready low during exc", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R8 exc one cycle", 64'(exc_valid), 64'd0);
        check("R8 still no mem_valid", 64'(mem_valid), 64'd0);
      end else begin
        check("R2 mem_valid", 64'(mem_valid), 64'd1);
        check("R2 mem_addr",  64'(mem_addr),  64'(v.addr & 32'hFFFF_FFF8));
        check("R2 mem_we",    64'(mem_we),    64'(v.st));
        check("R3 mem_be",    64'(mem_be),    64'(v.be));
        check("R9 ready low", 64'(req_ready), 64'd0);
        if (v.st) begin
          check("R4 mem_wdata", mem_wdata, v.expd);
          @(negedge clk);
          check("R2 mem_valid drops", 64'(mem_valid), 64'd0);
        end else begin
          @(negedge clk);
          check("R2 mem_valid drops", 64'(mem_valid), 64'd0);
          check("R9 ready low awaiting data", 64'(req_ready), 64'd0);
          mem_rvalid = 1'b1; mem_rdata = v.data;
          @(negedge clk);
          mem_rvalid = 1'b0;
          check("R10 ld_valid", 64'(ld_valid), 64'd1);
          if (v.sz == 2'd3)      check("R7 ld_data dword", ld_data, v.expd);
          else if (v.uns)        check("R6 ld_data zero fill", ld_data, v.expd);
          else                   check("R5 ld_data sign fill", ld_data, v.expd);
          @(negedge clk);
          check("R10 ld_valid one cycle", 64'(ld_valid), 64'd0);
        end
      end
    end

    // Back-pressure and requests while busy (R2, R9)
    mem_ready = 1'b0;
    drive_req(1'b1, 2'd0, 1'b0, 32'h2001, 64'h00000000000000A5);
    @(negedge clk);
    drive_req(1'b0, 2'd3, 1'b0, 32'h3000, 64'h0);
    for (int k = 0; k < 3; k++) begin
      check("R2 held mem_valid", 64'(mem_valid), 64'd1);
      check("R2 held mem_addr", 64'(mem_addr), 64'h2000);
      check("R4 held mem_wdata", mem_wdata, 64'h000000000000A500);
      check("R9 busy ignores request", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 mem_valid drops after handshake", 64'(mem_valid), 64'd0);
    check("R9 ready again", 64'(req_ready), 64'd1);
    @(negedge clk);
    check("R9 ignored request not issued", 64'(mem_valid), 64'd0);
    @(negedge clk);
    check("R9 still idle", 64'(mem_valid), 64'd0);

    // read data strobe with no load pending is ignored (R10)
    mem_rvalid = 1'b1; mem_rdata = 64'h1;
    @(negedge clk);
    mem_rvalid = 1'b0;
    check("R10 no ld_valid when idle", 64'(ld_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule